// File: doc/BRIEF.md
# Serial Port Interrupt Identifier

This block gathers the interrupt causes of a serial port and ranks them. It reports the most urgent cause that is enabled as a 3-bit cause code. Next to that code it drives a pending flag that is low when true, and a single interrupt request line. A register front end reads the 4-bit identification value and pulses the read and write strobes back into the block. The FIFOs around it provide fill levels and push/pop strobes.

The block holds one sticky latch for each event-type cause: line errors, receive timeout, transmit empty, modem change and baud-monitor completion. The receive-data-ready cause follows the receive FIFO level directly. The block also contains the receive character-timeout counter, whose limit is a programmable 16-bit value.

Top module: `uart_irq_ident`

## Requirements
- R1: `iid[0]` is 0 exactly when at least one enabled cause is active, and `irq` is its inverse. With nothing pending, `iid` reads 4'b0001, and it reads 4'b0001 during reset.
- R2: Any bit of `line_err` sets the line-error cause. That cause reports code 3'b011 (`iid` = 4'b0110), outranks every other cause, and stays set until an `lsr_rd` pulse.
- R3: Receive-data-ready is active while `rx_level` is at least the threshold chosen by `rx_trig_sel`, or while `rx_level` equals RX_DEPTH. The thresholds are 0→1, 1→RX_DEPTH/4, 2→RX_DEPTH/2 and 3→RX_DEPTH-2. It reports code 3'b010 (`iid` = 4'b0100) and drops as soon as the level falls below the threshold.
- R4: While `rx_level` is nonzero, the timeout cause sets on the clock edge that completes `rx_tmo_val` consecutive cycles with no push, pop or FIFO clear, counted from the last such event. Any of those events, or an empty FIFO, restarts the count. A value of 0 disables the timeout.
- R5: The timeout cause reports code 3'b110 (`iid` = 4'b1100) and clears on `rbr_rd` or `rx_fifo_clr`. When receive-data-ready is active at the same time, 3'b010 is reported instead.
- R6: A rising edge of `tx_empty` sets the transmit-empty cause, code 3'b001 (`iid` = 4'b0010). It clears on `thr_wr`. It also clears on `iid_rd`, but only in a cycle where transmit-empty is the reported cause.
- R7: Any bit of `modem_delta` sets the modem cause, code 3'b000 (`iid` = 4'b0000), which clears on `msr_rd`.
- R8: `bmon_done` sets the baud-monitor cause, code 3'b100 (`iid` = 4'b1000), which has the lowest priority and clears on `bmon_rd`.
- R9: `src_en` bit i gates cause i before ranking. The bit order is 0 line error, 1 data ready, 2 timeout, 3 transmit empty, 4 modem, 5 baud monitor. A disabled cause still latches and appears once it is enabled.
- R10: A set and a clear of the same latched cause in one cycle leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_en | input | 6 | Per-cause enables |
| line_err | input | 4 | Parity, overrun, framing and break event pulses |
| lsr_rd | input | 1 | Line status register read strobe |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trig_sel | input | 2 | Receive trigger threshold select |
| rx_push | input | 1 | Receive FIFO push strobe |
| rx_pop | input | 1 | Receive FIFO pop strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| rx_fifo_clr | input | 1 | Receive FIFO clear strobe |
| rx_tmo_val | input | TMO_W | Character timeout in clock cycles |
| tx_empty | input | 1 | Transmit FIFO empty flag |
| thr_wr | input | 1 | Transmit holding register write strobe |
| iid_rd | input | 1 | Identification register read strobe |
| modem_delta | input | 4 | Modem input change pulses |
| msr_rd | input | 1 | Modem status register read strobe |
| bmon_done | input | 1 | Baud monitor done pulse |
| bmon_rd | input | 1 | Baud monitor register read strobe |
| iid | output | 4 | {cause code, pending_n} |
| irq | output | 1 | Interrupt request |

## Verification
Some properties are checked by assertions on every cycle. The latches must hold until their clear, and a set must win over a clear in the same cycle. The timeout counter must restart after a push, a pop, a FIFO clear or an empty FIFO, and it must never fire while the timeout is disabled. The ranking must pick one cause at most, line errors must always win, and the idle code must hold. Other behaviour can only be shown by the bench's scenarios, which compare against a reference model on every clock. These include the exact cycle on which a timeout fires, the threshold table, and whether a read of the identification value clears transmit-empty, which depends on the reported cause. They also include the way disabled causes reappear once enabled.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NSRC   = 6;
  localparam int SRC_LS  = 0;
  localparam int SRC_RDA = 1;
  localparam int SRC_TO  = 2;
  localparam int SRC_TE  = 3;
  localparam int SRC_MS  = 4;
  localparam int SRC_BM  = 5;

  // cause code reported for each ranked source index
  function automatic logic [2:0] src_code(input int idx);
    case (idx)
      SRC_LS:  return 3'b011;
      SRC_RDA: return 3'b010;
      SRC_TO:  return 3'b110;
      SRC_TE:  return 3'b001;
      SRC_MS:  return 3'b000;
      default: return 3'b100;
    endcase
  endfunction

  // receive threshold chosen by the 2-bit select
  function automatic int unsigned rx_threshold(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction

  function automatic logic rx_ready(input int unsigned level, input logic [1:0] sel,
                                    input int unsigned depth);
    return (level >= rx_threshold(sel, depth)) || (level == depth);
  endfunction

endpackage

// File: rtl/uart_irq_src_latch.sv
module uart_irq_src_latch #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);

  generate
    for (genvar i = 0; i < N; i++) begin : g_lat
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= set[i] | (bit_q & ~clr[i]);
      end
      assign q[i] = bit_q;

      p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set[i] |=> q[i]);
      p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q[i] && !clr[i]) |=> q[i]);
      p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && !set[i]) |=> !q[i]);
    end
  endgenerate

endmodule

// File: rtl/uart_irq_rx_timeout.sv
module uart_irq_rx_timeout #(
  parameter int TMO_W = 16,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             rx_fifo_clr,
  input  logic [TMO_W-1:0] tmo_val,
  output logic             fire
);

  logic [TMO_W-1:0] cnt_q;
  logic             count_ok;
  logic             below_lim;

  // reaching limit-1 while counting means this edge completes the window
  function automatic logic hits_limit(input logic [TMO_W-1:0] cnt, input logic [TMO_W-1:0] lim);
    return (lim != '0) && (cnt == lim - 1'b1);
  endfunction

  assign count_ok  = (rx_level != '0) && !rx_push && !rx_pop && !rx_fifo_clr;
  assign below_lim = cnt_q < tmo_val;
  assign fire      = count_ok && hits_limit(cnt_q, tmo_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!count_ok) cnt_q <= '0;
    else if (below_lim) cnt_q <= cnt_q + 1'b1;
  end

  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push || rx_pop || rx_fifo_clr || rx_level == '0) |=> cnt_q == '0);
  p_fire_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> rx_level != '0);
  p_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_val == '0) |-> !fire);

endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] win,
  output logic [2:0]   code,
  output logic         pending
);

  always_comb begin
    logic found;
    found = 1'b0;
    win   = '0;
    code  = 3'b000;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        found  = 1'b1;
        win[i] = 1'b1;
        code   = src_code(i);
      end
    end
    pending = found;
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter  int RX_DEPTH = 16,
  parameter  int TMO_W    = 16,
  localparam int LVL_W    = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_en,
  input  logic [3:0]       line_err,
  input  logic             lsr_rd,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [1:0]       rx_trig_sel,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             rbr_rd,
  input  logic             rx_fifo_clr,
  input  logic [TMO_W-1:0] rx_tmo_val,
  input  logic             tx_empty,
  input  logic             thr_wr,
  input  logic             iid_rd,
  input  logic [3:0]       modem_delta,
  input  logic             msr_rd,
  input  logic             bmon_done,
  input  logic             bmon_rd,
  output logic [3:0]       iid,
  output logic             irq
);

  localparam int NLAT = NSRC - 1;

  logic            tx_empty_q;
  logic            te_rise;
  logic            to_fire;
  logic            rda_lvl;
  logic [NLAT-1:0] lat_set;
  logic [NLAT-1:0] lat_clr;
  logic [NLAT-1:0] lat_q;
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] req_en;
  logic [NSRC-1:0] win;
  logic [2:0]      code;
  logic            pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_empty_q <= 1'b0;
    else        tx_empty_q <= tx_empty;
  end

  assign te_rise = tx_empty & ~tx_empty_q;
  assign rda_lvl = rx_ready(int'(rx_level), rx_trig_sel, RX_DEPTH);

  uart_irq_rx_timeout #(.TMO_W(TMO_W), .LVL_W(LVL_W)) u_tmo (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_level    (rx_level),
    .rx_push     (rx_push),
    .rx_pop      (rx_pop),
    .rx_fifo_clr (rx_fifo_clr),
    .tmo_val     (rx_tmo_val),
    .fire        (to_fire)
  );

  // latch order: 0 line error, 1 timeout, 2 tx empty, 3 modem, 4 baud monitor
  assign lat_set = {bmon_done, |modem_delta, te_rise, to_fire, |line_err};
  assign lat_clr = {bmon_rd, msr_rd, thr_wr | (iid_rd & win[SRC_TE]),
                    rbr_rd | rx_fifo_clr, lsr_rd};

  uart_irq_src_latch #(.N(NLAT)) u_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (lat_set),
    .clr   (lat_clr),
    .q     (lat_q)
  );

  assign req    = {lat_q[4], lat_q[3], lat_q[2], lat_q[1], rda_lvl, lat_q[0]};
  assign req_en = req & src_en;

  uart_irq_arbiter #(.N(NSRC)) u_arb (
    .req     (req_en),
    .win     (win),
    .code    (code),
    .pending (pending)
  );

  assign iid = {code, ~pending};
  assign irq = pending;

  p_one_winner_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win));
  p_idle_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> iid == 4'b0001);
  p_ls_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q[0] && src_en[SRC_LS]) |-> iid == 4'b0110);
  p_rda_over_to_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en[SRC_RDA] && !req_en[SRC_LS]) |-> iid == 4'b0100);
  p_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en == '0) |-> !irq);

endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;

  localparam int CLK_P = 10;
  localparam int DEPTH = 16;
  localparam int TW    = 16;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    src_en = 6'h3F;
  logic [3:0]    line_err = '0;
  logic          lsr_rd = 0, rx_push = 0, rx_pop = 0, rbr_rd = 0, rx_fifo_clr = 0;
  logic [LW-1:0] rx_level = '0;
  logic [1:0]    rx_trig_sel = '0;
  logic [TW-1:0] rx_tmo_val = '0;
  logic          tx_empty = 0, thr_wr = 0, iid_rd = 0, msr_rd = 0, bmon_done = 0, bmon_rd = 0;
  logic [3:0]    modem_delta = '0;
  logic [3:0]    iid;
  logic          irq;

  int  checks = 0;
  int  fails = 0;
  bit  done = 0;

  always #(CLK_P/2) clk = ~clk;

  uart_irq_ident #(.RX_DEPTH(DEPTH), .TMO_W(TW)) u_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .line_err(line_err), .lsr_rd(lsr_rd),
    .rx_level(rx_level), .rx_trig_sel(rx_trig_sel), .rx_push(rx_push), .rx_pop(rx_pop),
    .rbr_rd(rbr_rd), .rx_fifo_clr(rx_fifo_clr), .rx_tmo_val(rx_tmo_val),
    .tx_empty(tx_empty), .thr_wr(thr_wr), .iid_rd(iid_rd), .modem_delta(modem_delta),
    .msr_rd(msr_rd), .bmon_done(bmon_done), .bmon_rd(bmon_rd), .iid(iid), .irq(irq)
  );

  // ---------------- reference model ----------------
  bit m_ls, m_to, m_te, m_ms, m_bm, m_txp;
  int m_cnt;
  int thr_tab [4] = '{1, DEPTH/4, DEPTH/2, DEPTH-2};
  logic [2:0] code_tab [6] = '{3'b011, 3'b010, 3'b110, 3'b001, 3'b000, 3'b100};

  function automatic logic [3:0] model_iid();
    bit r [6];
    r[0] = m_ls;
    r[1] = (int'(rx_level) >= thr_tab[rx_trig_sel]) || (int'(rx_level) == DEPTH);
    r[2] = m_to; r[3] = m_te; r[4] = m_ms; r[5] = m_bm;
    for (int i = 0; i < 6; i++)
      if (r[i] && src_en[i]) return {code_tab[i], 1'b0};
    return 4'b0001;
  endfunction

  function automatic string tag_of(input logic [3:0] v);
    case (v)
      4'b0110: return "R2";
      4'b0100: return "R3";
      4'b1100: return "R5";
      4'b0010: return "R6";
      4'b0000: return "R7";
      4'b1000: return "R8";
      default: return "R1";
    endcase
  endfunction

  always @(posedge clk) begin : model_step
    logic [3:0] cur;
    bit fire;
    int lim;
    if (!rst_n) begin
      m_ls = 0; m_to = 0; m_te = 0; m_ms = 0; m_bm = 0; m_txp = 0; m_cnt = 0;
    end else begin
      cur  = model_iid();
      fire = 0;
      lim  = int'(rx_tmo_val);
      if (rx_level == '0 || rx_push || rx_pop || rx_fifo_clr) m_cnt = 0;
      else if (lim != 0 && m_cnt < lim) begin
        if (m_cnt == lim - 1) fire = 1;
        m_cnt++;
      end
      m_ls = (|line_err) || (m_ls && !lsr_rd);
      m_to = fire || (m_to && !(rbr_rd || rx_fifo_clr));
      m_te = (tx_empty && !m_txp) || (m_te && !(thr_wr || (iid_rd && cur == 4'b0010)));
      m_ms = (|modem_delta) || (m_ms && !msr_rd);
      m_bm = bmon_done || (m_bm && !bmon_rd);
      m_txp = tx_empty;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin : model_cmp
    logic [3:0] e;
    if (rst_n && !done) begin
      e = model_iid();
      checks++;
      if (iid !== e || irq !== ~e[0]) begin
        fails++;
        $display("FAIL %s per-cycle: iid=%b irq=%b expected iid=%b irq=%b",
                 tag_of(e), iid, irq, e, ~e[0]);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic chk(input logic [3:0] exp, input string req);
    @(negedge clk); #1;
    checks++;
    if (iid !== exp || irq !== ~exp[0]) begin
      fails++;
      $display("FAIL %s: iid=%b irq=%b expected iid=%b irq=%b", req, iid, irq, exp, ~exp[0]);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: state=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1 reset state
    tick(2);
    chk(4'b0001, "R1");
    rst_n = 1'b1;
    tick(2);
    chk(4'b0001, "R1");

    // R2 line error latch and clear
    line_err = 4'b0100; tick(1); line_err = '0;
    chk(4'b0110, "R2");
    tick(3);
    chk(4'b0110, "R2");
    lsr_rd = 1; tick(1); lsr_rd = 0;
    chk(4'b0001, "R2");

    // R10 set beats clear
    line_err = 4'b0001; lsr_rd = 1; tick(1); line_err = '0; lsr_rd = 0;
    chk(4'b0110, "R10");
    lsr_rd = 1; tick(1); lsr_rd = 0;
    chk(4'b0001, "R10");

    // R3 thresholds
    rx_trig_sel = 2'd1; rx_level = 3; tick(1); chk(4'b0001, "R3");
    rx_level = 4; tick(1); chk(4'b0100, "R3");
    rx_trig_sel = 2'd3; rx_level = 13; tick(1); chk(4'b0001, "R3");
    rx_level = 14; tick(1); chk(4'b0100, "R3");
    rx_trig_sel = 2'd2; rx_level = 7; tick(1); chk(4'b0001, "R3");
    rx_level = 8; tick(1); chk(4'b0100, "R3");
    rx_trig_sel = 2'd3; rx_level = 16; tick(1); chk(4'b0100, "R3");
    rx_level = 0; tick(1);

    // R4 timeout fires exactly after the programmed window
    rx_tmo_val = 5; rx_level = 2; rx_push = 1; tick(1); rx_push = 0;
    tick(4); chk(4'b0001, "R4");
    tick(1); chk(4'b1100, "R4");

    // R5 data-ready outranks timeout, then clears
    rx_trig_sel = 2'd0; tick(1); chk(4'b0100, "R5");
    rx_trig_sel = 2'd3; tick(1); chk(4'b1100, "R5");
    rbr_rd = 1; tick(1); rbr_rd = 0;
    chk(4'b0001, "R5");
    rx_pop = 1; tick(1); rx_pop = 0;
    tick(5); chk(4'b1100, "R5");
    rx_fifo_clr = 1; rx_level = 0; tick(1); rx_fifo_clr = 0;
    chk(4'b0001, "R5");

    // R4 disabled with zero limit
    rx_tmo_val = 0; rx_level = 2; rx_push = 1; tick(1); rx_push = 0;
    tick(20); chk(4'b0001, "R4");
    rx_level = 0; tick(1);

    // R6 transmit empty
    tx_empty = 1; tick(1); chk(4'b0010, "R6");
    iid_rd = 1; tick(1); iid_rd = 0; chk(4'b0001, "R6");
    tx_empty = 0; tick(1); tx_empty = 1; tick(1); chk(4'b0010, "R6");
    thr_wr = 1; tick(1); thr_wr = 0; chk(4'b0001, "R6");
    tx_empty = 0; tick(1);
    line_err = 4'b1000; tx_empty = 1; tick(1); line_err = '0;
    chk(4'b0110, "R6");
    iid_rd = 1; tick(1); iid_rd = 0; chk(4'b0110, "R6");
    lsr_rd = 1; tick(1); lsr_rd = 0; chk(4'b0010, "R6");
    thr_wr = 1; tick(1); thr_wr = 0; chk(4'b0001, "R6");

    // R7 modem change
    modem_delta = 4'b1000; tick(1); modem_delta = '0; chk(4'b0000, "R7");
    msr_rd = 1; tick(1); msr_rd = 0; chk(4'b0001, "R7");

    // R8 baud monitor, lowest priority
    bmon_done = 1; tick(1); bmon_done = 0; chk(4'b1000, "R8");
    modem_delta = 4'b0001; tick(1); modem_delta = '0; chk(4'b0000, "R8");
    msr_rd = 1; tick(1); msr_rd = 0; chk(4'b1000, "R8");
    bmon_rd = 1; tick(1); bmon_rd = 0; chk(4'b0001, "R8");

    // R9 enable gating keeps the latch
    src_en = 6'h3E; line_err = 4'b0010; tick(1); line_err = '0;
    chk(4'b0001, "R9");
    src_en = 6'h3F; tick(1); chk(4'b0110, "R9");
    lsr_rd = 1; tick(1); lsr_rd = 0; chk(4'b0001, "R9");

    tick(2);
    done = 1;
    summary();
    $finish;
  end

endmodule